// File: doc/BRIEF.md
# DMA Address Map Translator

This block turns an I/O-bus DMA address into a main-memory byte address by looking up a translation entry kept in main memory. The table starts at a programmable base address. Each I/O-bus page has one 32-bit entry in the table, at the page number times four, limited by the table-index mask and added to the base. The block reads that entry with a single memory request, checks it, and produces the physical address. Instead of an address, the result can be one of two error reports for the error-register block. A master error carries the offending bus page. A slave error carries the offending memory page.

The block handles one request at a time. A DMA engine walking a multi-unit buffer can mark a request as a continuation. If that request falls in the same bus page as the last successful translation, and its page offset is not zero, the held translation is reused and no memory read is made. A zero offset marks a page crossing and always causes a fresh lookup.

Top module: `dmx_map_xlate`

## Requirements
- R1: While reset is asserted and in the first cycle after its release, `mem_req`, `done`, `ok`, `merr_stb` and `serr_stb` are all low.
- R2: On a request that needs a lookup, `mem_req` rises in the cycle after `start`. `mem_addr` equals ((bus page × 4) AND (4 × MAP_ENTRIES − 1)) + `map_base`, where the bus page is `bus_addr` >> 9. Both hold until the cycle in which `mem_valid` is seen.
- R3: An entry with bit 31 set yields `done` and `ok` two cycles after the `mem_valid` cycle, with `phys_addr` = (entry bits 19:0) << 9 + (`bus_addr` bits 8:0), provided that address is below MEM_BYTES.
- R4: If the entry address is not below MEM_BYTES, no memory request is made. `done` comes in the cycle after `start` with `ok` low, `serr_stb` high and `serr_page` = 0.
- R5: An entry with bit 31 clear gives `done` with `ok` low, `merr_stb` high and `merr_page` = the bus page.
- R6: A valid entry whose translated address is at or above MEM_BYTES gives `done` with `ok` low, `serr_stb` high and `serr_page` = translated address >> 9.
- R7: A request with `cont` high, a nonzero page offset and the same bus page as the last successful translation makes no memory request. It completes with `ok` in the cycle after `start`, using the held memory page.
- R8: A continuation at offset 0, on a different bus page, or after a failed translation performs a full lookup.
- R9: `start` while a request is in progress, and `mem_valid` while no read is pending, have no effect.
- R10: `done` lasts exactly one cycle. The error strobes appear only with `done`, and exactly one of `ok`, `merr_stb`, `serr_stb` is high with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request strobe, taken only when idle |
| cont | input | 1 | Request continues the previous transfer |
| bus_addr | input | BUS_AW | I/O-bus DMA byte address |
| map_base | input | PA_W | Byte address of the translation table |
| mem_req | output | 1 | Entry read pending |
| mem_addr | output | PA_W | Entry byte address |
| mem_valid | input | 1 | Entry read data valid |
| mem_data | input | 32 | Entry read data |
| done | output | 1 | One-cycle completion pulse |
| ok | output | 1 | Translation succeeded (with done) |
| phys_addr | output | PA_W | Translated memory byte address |
| merr_stb | output | 1 | Master error report |
| merr_page | output | BUS_AW-9 | Bus page of the master error |
| serr_stb | output | 1 | Slave error report |
| serr_page | output | PA_W-9 | Memory page of the slave error |

## Verification
The bench covers several boundaries. A translated address exactly one byte above the last good page must give a slave error; a design comparing with "at or below" would report success. A table whose base pushes the entry address past memory must fail without a read; a design that fetches anyway would hang or raise the wrong error. Continuations at offset zero, on another page, or after a failure must refetch; a design that trusts a stale hold would return a wrong address with no read. Stray `start` and `mem_valid` pulses are injected to catch a design that restarts or advances on them.

// File: rtl/dmx_pkg.sv
// Shared types of the DMA map translator: sequencer states and outcome kinds.
package dmx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FETCH  = 2'd1,
        ST_CHECK  = 2'd2,
        ST_RESULT = 2'd3
    } dmx_state_e;

    typedef enum logic [1:0] {
        RK_OK   = 2'd0,
        RK_MERR = 2'd1,
        RK_SERR = 2'd2
    } dmx_kind_e;
endpackage

// File: rtl/dmx_entry_addr.sv
// Forms the byte address of a bus page's table entry and tells whether it
// lies inside existing memory. Assumes MAP_ENTRIES is a power of two.
module dmx_entry_addr #(
    parameter int          BUS_AW      = 22,
    parameter int          PA_W        = 32,
    parameter int          PAGE_SHIFT  = 9,
    parameter int          MAP_ENTRIES = 8192,
    parameter int unsigned MEM_BYTES   = 1048576
) (
    input  logic [BUS_AW-PAGE_SHIFT-1:0] bus_page,
    input  logic [PA_W-1:0]              map_base,
    output logic [PA_W-1:0]              entry_addr,
    output logic                         entry_exists
);
    localparam int              BPG_W     = BUS_AW - PAGE_SHIFT;
    localparam logic [PA_W-1:0] IDX_MASK  = PA_W'(MAP_ENTRIES * 4 - 1);
    localparam logic [PA_W:0]   MEM_LIMIT = (PA_W+1)'(MEM_BYTES);

    logic [PA_W-1:0] scaled_idx;

    // Scale page number to a byte index, clip to table size, add base.
    always_comb begin
        scaled_idx   = PA_W'({bus_page, 2'b00}) & IDX_MASK;
        entry_addr   = scaled_idx + map_base;
        entry_exists = ({1'b0, entry_addr} < MEM_LIMIT);
    end

    logic unused_w;
    assign unused_w = (BPG_W == 0);
endmodule

// File: rtl/dmx_entry_check.sv
// Judges a fetched table entry: valid bit, then range of the translated
// address. Pure combinational; the sequencer registers the outcome.
module dmx_entry_check
    import dmx_pkg::*;
#(
    parameter int          PA_W       = 32,
    parameter int          PAGE_SHIFT = 9,
    parameter int          ENTRY_W    = 32,
    parameter int          EPG_W      = 20,
    parameter int unsigned MEM_BYTES  = 1048576
) (
    input  logic [ENTRY_W-1:0]         entry,
    input  logic [PAGE_SHIFT-1:0]      offset,
    output dmx_kind_e                  kind,
    output logic [PA_W-1:0]            phys,
    output logic [PA_W-PAGE_SHIFT-1:0] spage
);
    localparam int            VALID_BIT = ENTRY_W - 1;
    localparam logic [PA_W:0] MEM_LIMIT = (PA_W+1)'(MEM_BYTES);

    // Build the candidate address and classify the entry.
    always_comb begin
        phys  = PA_W'({entry[EPG_W-1:0], offset});
        spage = phys[PA_W-1:PAGE_SHIFT];
        if (!entry[VALID_BIT])
            kind = RK_MERR;
        else if ({1'b0, phys} >= MEM_LIMIT)
            kind = RK_SERR;
        else
            kind = RK_OK;
    end
endmodule

// File: rtl/dmx_page_hold.sv
// Holds the last successful translation so that continuation requests
// inside the same bus page skip the table read. Cleared by any failure.
module dmx_page_hold #(
    parameter int PA_W       = 32,
    parameter int PAGE_SHIFT = 9,
    parameter int BPG_W      = 13,
    parameter int EPG_W      = 20
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cont,
    input  logic [BPG_W-1:0]      bus_page_in,
    input  logic [PAGE_SHIFT-1:0] offset_in,
    input  logic                  upd_en,
    input  logic                  upd_ok,
    input  logic [BPG_W-1:0]      upd_bpage,
    input  logic [EPG_W-1:0]      upd_mpage,
    output logic                  hit,
    output logic [PA_W-1:0]       held_phys
);
    logic             valid_q;
    logic [BPG_W-1:0] bpage_q;
    logic [EPG_W-1:0] mpage_q;

    // Record a translation outcome: keep on success, drop on failure.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            bpage_q <= '0;
            mpage_q <= '0;
        end else if (upd_en) begin
            valid_q <= upd_ok;
            if (upd_ok) begin
                bpage_q <= upd_bpage;
                mpage_q <= upd_mpage;
            end
        end
    end

    // Reuse only mid-page within the same bus page; offset 0 is a crossing.
    always_comb begin
        hit       = cont && valid_q && (offset_in != '0) && (bus_page_in == bpage_q);
        held_phys = PA_W'({mpage_q, offset_in});
    end
endmodule

// File: rtl/dmx_seq.sv
// Request sequencer: idle, entry fetch, entry check, one-cycle result.
// Assumes mem_valid is only meaningful while mem_req is high.
module dmx_seq
    import dmx_pkg::*;
#(
    parameter int BUS_AW     = 22,
    parameter int PA_W       = 32,
    parameter int PAGE_SHIFT = 9,
    parameter int ENTRY_W    = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start,
    input  logic [BUS_AW-1:0]            bus_addr,
    input  logic                         hit,
    input  logic [PA_W-1:0]              held_phys,
    input  logic [PA_W-1:0]              entry_addr,
    input  logic                         entry_exists,
    input  logic                         mem_valid,
    input  logic [ENTRY_W-1:0]           mem_data,
    input  dmx_kind_e                    chk_kind,
    input  logic [PA_W-1:0]              chk_phys,
    input  logic [PA_W-PAGE_SHIFT-1:0]   chk_spage,
    output logic [BUS_AW-1:0]            bus_q,
    output logic [ENTRY_W-1:0]           ent_q,
    output logic                         mem_req,
    output logic [PA_W-1:0]              mem_addr,
    output logic                         done,
    output logic                         ok,
    output logic [PA_W-1:0]              phys_addr,
    output logic                         merr_stb,
    output logic [BUS_AW-PAGE_SHIFT-1:0] merr_page,
    output logic                         serr_stb,
    output logic [PA_W-PAGE_SHIFT-1:0]   serr_page,
    output logic                         upd_en,
    output logic                         upd_ok
);
    dmx_state_e                 state_q;
    dmx_kind_e                  res_kind_q;
    logic [PA_W-1:0]            res_phys_q;
    logic [PA_W-PAGE_SHIFT-1:0] res_spage_q;
    logic [PA_W-1:0]            addr_q;

    // Advance the request through its phases and capture the outcome.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            res_kind_q  <= RK_OK;
            res_phys_q  <= '0;
            res_spage_q <= '0;
            addr_q      <= '0;
            bus_q       <= '0;
            ent_q       <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        bus_q <= bus_addr;
                        if (hit) begin
                            res_kind_q <= RK_OK;
                            res_phys_q <= held_phys;
                            state_q    <= ST_RESULT;
                        end else if (!entry_exists) begin
                            res_kind_q  <= RK_SERR;
                            res_spage_q <= '0;
                            state_q     <= ST_RESULT;
                        end else begin
                            addr_q  <= entry_addr;
                            state_q <= ST_FETCH;
                        end
                    end
                end
                ST_FETCH: begin
                    if (mem_valid) begin
                        ent_q   <= mem_data;
                        state_q <= ST_CHECK;
                    end
                end
                ST_CHECK: begin
                    res_kind_q  <= chk_kind;
                    res_phys_q  <= chk_phys;
                    res_spage_q <= chk_spage;
                    state_q     <= ST_RESULT;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Tell the page hold when an outcome is final and whether it succeeded.
    always_comb begin
        upd_en = (state_q == ST_CHECK) ||
                 ((state_q == ST_IDLE) && start && !hit && !entry_exists);
        upd_ok = (state_q == ST_CHECK) && (chk_kind == RK_OK);
    end

    // Drive the memory port and the result pulses.
    always_comb begin
        mem_req   = (state_q == ST_FETCH);
        mem_addr  = addr_q;
        done      = (state_q == ST_RESULT);
        ok        = done && (res_kind_q == RK_OK);
        merr_stb  = done && (res_kind_q == RK_MERR);
        serr_stb  = done && (res_kind_q == RK_SERR);
        phys_addr = res_phys_q;
        merr_page = bus_q[BUS_AW-1:PAGE_SHIFT];
        serr_page = res_spage_q;
    end
endmodule

// File: rtl/dmx_map_xlate.sv
// DMA address map translator top. Looks up a per-page entry in a memory
// resident table at map_base and returns a physical address or an error.
// Assumes one outstanding entry read and a memory that answers it.
module dmx_map_xlate
    import dmx_pkg::*;
#(
    parameter int          BUS_AW      = 22,
    parameter int          PA_W        = 32,
    parameter int          PAGE_SHIFT  = 9,
    parameter int          MAP_ENTRIES = 8192,
    parameter int unsigned MEM_BYTES   = 1048576
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start,
    input  logic                         cont,
    input  logic [BUS_AW-1:0]            bus_addr,
    input  logic [PA_W-1:0]              map_base,
    output logic                         mem_req,
    output logic [PA_W-1:0]              mem_addr,
    input  logic                         mem_valid,
    input  logic [31:0]                  mem_data,
    output logic                         done,
    output logic                         ok,
    output logic [PA_W-1:0]              phys_addr,
    output logic                         merr_stb,
    output logic [BUS_AW-PAGE_SHIFT-1:0] merr_page,
    output logic                         serr_stb,
    output logic [PA_W-PAGE_SHIFT-1:0]   serr_page
);
    localparam int ENTRY_W = 32;
    localparam int EPG_W   = 20;
    localparam int BPG_W   = BUS_AW - PAGE_SHIFT;

    logic [PA_W-1:0]            entry_addr;
    logic                       entry_exists;
    logic                       hit;
    logic [PA_W-1:0]            held_phys;
    logic [BUS_AW-1:0]          bus_q;
    logic [ENTRY_W-1:0]         ent_q;
    dmx_kind_e                  chk_kind;
    logic [PA_W-1:0]            chk_phys;
    logic [PA_W-PAGE_SHIFT-1:0] chk_spage;
    logic                       upd_en;
    logic                       upd_ok;

    dmx_entry_addr #(
        .BUS_AW(BUS_AW), .PA_W(PA_W), .PAGE_SHIFT(PAGE_SHIFT),
        .MAP_ENTRIES(MAP_ENTRIES), .MEM_BYTES(MEM_BYTES)
    ) u_eaddr (
        .bus_page    (bus_addr[BUS_AW-1:PAGE_SHIFT]),
        .map_base    (map_base),
        .entry_addr  (entry_addr),
        .entry_exists(entry_exists)
    );

    dmx_page_hold #(
        .PA_W(PA_W), .PAGE_SHIFT(PAGE_SHIFT), .BPG_W(BPG_W), .EPG_W(EPG_W)
    ) u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .cont       (cont),
        .bus_page_in(bus_addr[BUS_AW-1:PAGE_SHIFT]),
        .offset_in  (bus_addr[PAGE_SHIFT-1:0]),
        .upd_en     (upd_en),
        .upd_ok     (upd_ok),
        .upd_bpage  (bus_q[BUS_AW-1:PAGE_SHIFT]),
        .upd_mpage  (ent_q[EPG_W-1:0]),
        .hit        (hit),
        .held_phys  (held_phys)
    );

    dmx_entry_check #(
        .PA_W(PA_W), .PAGE_SHIFT(PAGE_SHIFT), .ENTRY_W(ENTRY_W),
        .EPG_W(EPG_W), .MEM_BYTES(MEM_BYTES)
    ) u_check (
        .entry (ent_q),
        .offset(bus_q[PAGE_SHIFT-1:0]),
        .kind  (chk_kind),
        .phys  (chk_phys),
        .spage (chk_spage)
    );

    dmx_seq #(
        .BUS_AW(BUS_AW), .PA_W(PA_W), .PAGE_SHIFT(PAGE_SHIFT), .ENTRY_W(ENTRY_W)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .bus_addr    (bus_addr),
        .hit         (hit),
        .held_phys   (held_phys),
        .entry_addr  (entry_addr),
        .entry_exists(entry_exists),
        .mem_valid   (mem_valid),
        .mem_data    (mem_data),
        .chk_kind    (chk_kind),
        .chk_phys    (chk_phys),
        .chk_spage   (chk_spage),
        .bus_q       (bus_q),
        .ent_q       (ent_q),
        .mem_req     (mem_req),
        .mem_addr    (mem_addr),
        .done        (done),
        .ok          (ok),
        .phys_addr   (phys_addr),
        .merr_stb    (merr_stb),
        .merr_page   (merr_page),
        .serr_stb    (serr_stb),
        .serr_page   (serr_page),
        .upd_en      (upd_en),
        .upd_ok      (upd_ok)
    );
endmodule

// File: rtl/dmx_checker.sv
// Protocol checks on the translator's ports, attached by bind.
module dmx_checker #(
    parameter int PA_W = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            mem_req,
    input logic            mem_valid,
    input logic [PA_W-1:0] mem_addr,
    input logic            done,
    input logic            ok,
    input logic            merr_stb,
    input logic            serr_stb
);
    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R10
    strobe_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (merr_stb || serr_stb) |-> done);
    // R10
    single_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($countones({ok, merr_stb, serr_stb}) == 1));
    // R2
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_valid) |=> (mem_req && $stable(mem_addr)));
    // R9
    no_done_while_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !done);
    // R3
    done_after_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_valid) |=> (!mem_req && !done) ##1 done);
endmodule

bind dmx_map_xlate dmx_checker #(.PA_W(PA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mem_req  (mem_req),
    .mem_valid(mem_valid),
    .mem_addr (mem_addr),
    .done     (done),
    .ok       (ok),
    .merr_stb (merr_stb),
    .serr_stb (serr_stb)
);

// File: tb/sim_dmx_map_xlate.sv
// Bench: behavioural table memory and translation model, compared each cycle.
module sim_dmx_map_xlate;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] MEM = 32'h0010_0000;

    logic        clk = 1'b0;
    logic        rst_n, start, cont, mem_valid;
    logic [21:0] bus_addr;
    logic [31:0] map_base, mem_data;
    logic        mem_req, done, ok, merr_stb, serr_stb;
    logic [31:0] mem_addr, phys_addr;
    logic [12:0] merr_page;
    logic [22:0] serr_page;

    int n_chk = 0;
    int n_fail = 0;

    bit h_valid = 0;
    int h_bpage = 0;
    int h_mpage = 0;
    logic [31:0] tab [int];

    always #(CLK_PERIOD/2) clk = ~clk;

    dmx_map_xlate u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .cont(cont),
        .bus_addr(bus_addr), .map_base(map_base),
        .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_valid(mem_valid), .mem_data(mem_data),
        .done(done), .ok(ok), .phys_addr(phys_addr),
        .merr_stb(merr_stb), .merr_page(merr_page),
        .serr_stb(serr_stb), .serr_page(serr_page)
    );

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    task automatic cmp(string tag, bit e_req, logic [31:0] e_addr, bit e_done, bit e_ok,
                       logic [31:0] e_phys, bit e_m, int e_mp, bit e_s, int e_sp);
        bit bad = 0;
        n_chk++;
        if (mem_req !== e_req) bad = 1;
        if (e_req && mem_addr !== e_addr) bad = 1;
        if (done !== e_done) bad = 1;
        if (ok !== (e_done && e_ok)) bad = 1;
        if (e_done && e_ok && phys_addr !== e_phys) bad = 1;
        if (merr_stb !== e_m) bad = 1;
        if (e_m && merr_page !== e_mp[12:0]) bad = 1;
        if (serr_stb !== e_s) bad = 1;
        if (e_s && serr_page !== e_sp[22:0]) bad = 1;
        if (bad) begin
            n_fail++;
            $display("FAIL %s: actual req=%0b addr=%h done=%0b ok=%0b phys=%h m=%0b/%h s=%0b/%h expected req=%0b addr=%h done=%0b ok=%0b phys=%h m=%0b/%h s=%0b/%h",
                     tag, mem_req, mem_addr, done, ok, phys_addr, merr_stb, merr_page, serr_stb, serr_page,
                     e_req, e_addr, e_done, e_ok, e_phys, e_m, e_mp, e_s, e_sp);
        end
    endtask

    task automatic idle(string tag);
        cmp(tag, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    // One request; expectations come from the model state and the table.
    task automatic run(string tag, int bpage, int off, bit c, int lat, bit poke);
        logic [31:0] eaddr, ent, ph;
        bit hit, early, e_ok, e_m, e_s;
        int e_sp;
        eaddr = ((32'(bpage) << 2) & 32'h7FFF) + map_base;
        hit   = c && h_valid && (off != 0) && (bpage == h_bpage);
        early = !hit && (eaddr >= MEM);
        ent   = tab.exists(bpage) ? tab[bpage] : 32'h0;
        e_ok = 0; e_m = 0; e_s = 0; e_sp = 0; ph = 0;
        if (hit) begin
            e_ok = 1; ph = 32'({h_mpage[19:0], 9'(off)});
        end else if (early) begin
            e_s = 1; h_valid = 0;
        end else if (!ent[31]) begin
            e_m = 1; h_valid = 0;
        end else begin
            ph = 32'({ent[19:0], 9'(off)});
            if (ph >= MEM) begin
                e_s = 1; e_sp = int'(ph >> 9); h_valid = 0;
            end else begin
                e_ok = 1; h_valid = 1; h_bpage = bpage; h_mpage = int'(ent[19:0]);
            end
        end
        start = 1; cont = c; bus_addr = 22'((bpage << 9) | off);
        @(negedge clk);
        start = 0; cont = 0;
        if (poke) begin start = 1; bus_addr = 22'h3FFFFF; end
        if (hit || early) begin
            cmp(tag, 0, 0, 1, e_ok, ph, e_m, bpage, e_s, e_sp);
        end else begin
            for (int i = 0; i <= lat; i++) begin
                cmp(tag, 1, eaddr, 0, 0, 0, 0, 0, 0, 0);
                if (i == lat) begin mem_valid = 1; mem_data = ent; end
                @(negedge clk);
                start = 0; mem_valid = 0;
            end
            cmp(tag, 0, 0, 0, 0, 0, 0, 0, 0, 0);
            @(negedge clk);
            cmp(tag, 0, 0, 1, e_ok, ph, e_m, bpage, e_s, e_sp);
        end
        @(negedge clk);
        idle("R10");
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        summary();
        $finish;
    end

    initial begin
        rst_n = 0; start = 0; cont = 0; mem_valid = 0; mem_data = 0;
        bus_addr = 0; map_base = 32'h000F_0000;
        tab[3]  = 32'h8000_0100;
        tab[5]  = 32'h0000_0100;
        tab[7]  = 32'h8000_0900;
        tab[9]  = 32'h8000_00FF;
        tab[10] = 32'h8000_07FF;
        tab[11] = 32'h8000_0800;
        for (int i = 0; i < 3; i++) begin @(negedge clk); idle("R1"); end
        rst_n = 1;
        @(negedge clk); idle("R1");

        run("R3", 3, 'h10, 0, 2, 0);     // also R2 on mem_addr
        run("R7", 3, 'h20, 1, 0, 0);     // held page reuse
        run("R8", 3, 'h0, 1, 0, 0);      // offset 0 forces lookup
        run("R7", 3, 'h1FF, 1, 0, 0);
        run("R5", 5, 'h4, 0, 1, 0);      // invalid entry
        run("R8", 5, 'h8, 1, 0, 0);      // after failure: lookup again
        run("R6", 7, 'h0, 0, 0, 0);      // translated beyond memory
        run("R9", 9, 'h40, 0, 0, 1);     // start during busy ignored
        run("R9", 9, 'h44, 0, 3, 1);
        run("R8", 10, 'h8, 1, 1, 0);     // other page: lookup, top page ok
        run("R6", 11, 'h0, 0, 0, 0);     // exactly at memory size
        run("R8", 11, 'h4, 1, 0, 0);     // hold cleared by the failure

        // R9: stray mem_valid while idle has no effect
        mem_valid = 1; mem_data = 32'hFFFF_FFFF;
        @(negedge clk); mem_valid = 0; idle("R9");
        @(negedge clk); idle("R9");

        map_base = 32'h000F_C000;
        run("R4", 'h1FFF, 'h0, 0, 0, 0); // entry address beyond memory
        run("R5", 0, 'h2, 0, 2, 0);      // entry inside memory, not valid
        run("R2", 'h100, 'h6, 0, 1, 0);

        summary();
        $finish;
    end
endmodule